// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator with Minimum Output

This block compares two unsigned operands of a parameterised width (eight bits by default) and reports one of three orderings: A above B, A equal to B, or A below B. The decision is made by a chain of one-bit cells. The chain starts at the top bit and ends at the bottom bit. Each cell passes a three-wire partial verdict to the cell below it. The first bit pair that differs decides the result. Any bit below that pair cannot change the verdict.

Three cascade inputs feed the top cell. These carry the verdict of a comparator that handles more significant bits. Wider operands can therefore be compared by chaining instances: the upper slice drives the cascade inputs of the lower slice. For a comparison on its own, drive the cascade as "equal" (greater low, equal high, less low).

A second output gives the minimum. A 2:1 selector passes A when the below flag is set and passes B in every other case. The whole block is combinational.

Top module: `mag_cmp_min`

## Requirements
- R1: With the cascade driven as equal only, `a_gt_b_o` is high exactly when `a_i` is greater than `b_i` as an unsigned number.
- R2: With the cascade driven as equal only, `a_eq_b_o` is high exactly when `a_i` and `b_i` hold the same value.
- R3: With the cascade driven as equal only, `a_lt_b_o` is high exactly when `a_i` is smaller than `b_i` as an unsigned number.
- R4: The most significant differing bit pair decides the verdict, and lower bits cannot change it. Example: 0x0B against 0x09 gives "greater", because bit 1 is the highest bit that differs. Another example: 0x80 against 0x7F gives "greater".
- R5: With only `casc_gt_i` high, the outputs are greater=1, equal=0, less=0 for any operands.
- R6: With only `casc_lt_i` high, the outputs are less=1, equal=0, greater=0 for any operands.
- R7: With all three cascade inputs low, all three output flags are low.
- R8: Whenever exactly one cascade input is high, exactly one output flag is high.
- R9: `min_o` equals `a_i` when `a_lt_b_o` is high and equals `b_i` otherwise. With the cascade driven as equal only, equal operands therefore give B.
- R10: Two instances in a chain give the same flags as one comparison of double width. In the chain, the upper instance works on the high halves with the cascade driven as equal only. Its three flags then drive the cascade inputs of the lower instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A, unsigned |
| b_i | input | WIDTH | Operand B, unsigned |
| casc_gt_i | input | 1 | Upper-slice verdict: A greater |
| casc_eq_i | input | 1 | Upper-slice verdict: equal so far |
| casc_lt_i | input | 1 | Upper-slice verdict: A smaller |
| a_gt_b_o | output | 1 | A greater than B |
| a_eq_b_o | output | 1 | A equal to B |
| a_lt_b_o | output | 1 | A smaller than B |
| min_o | output | WIDTH | Smaller operand (B on a tie) |

## Verification
The block holds no registers. A faulty cell therefore shows at the flags and at `min_o` in the same cycle as the operands that reach it. It only shows when the bits above that cell are equal, because otherwise the cell's equal wire is low. The operand tables are built so that the first differing pair falls at the top bit, at a middle bit and at the bottom bit. Random operands then cover the rest. A fault that breaks the cascade wiring shows up when forced cascade verdicts still reach the outputs unchanged, and when a two-instance chain is checked against a double-width comparison.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } verdict_t;
endpackage

// File: rtl/mag_bit_cell.sv
module mag_bit_cell
  import mag_cmp_pkg::*;
(
  input  logic     a_bit,
  input  logic     b_bit,
  input  verdict_t up_v,
  output verdict_t dn_v
);
  always_comb begin
    dn_v.gt = up_v.gt | (up_v.eq & a_bit & ~b_bit);
    dn_v.lt = up_v.lt | (up_v.eq & ~a_bit & b_bit);
    dn_v.eq = up_v.eq & ~(a_bit ^ b_bit);
  end
endmodule

// File: rtl/mag_cell_chain.sv
module mag_cell_chain
  import mag_cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_vec,
  input  logic [WIDTH-1:0] b_vec,
  input  verdict_t         top_v,
  output verdict_t         bot_v
);
  verdict_t link [WIDTH+1];

  assign link[WIDTH] = top_v;

  for (genvar k = WIDTH - 1; k >= 0; k--) begin : g_cell
    mag_bit_cell u_cell (
      .a_bit (a_vec[k]),
      .b_bit (b_vec[k]),
      .up_v  (link[k+1]),
      .dn_v  (link[k])
    );
  end

  assign bot_v = link[0];
endmodule

// File: rtl/mag_min_pick.sv
module mag_min_pick #(
  parameter int WIDTH = 8
) (
  input  logic             pick_a,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] picked
);
  always_comb begin
    if (pick_a) picked = opnd_a;
    else        picked = opnd_b;
  end
endmodule

// File: rtl/mag_cmp_min.sv
module mag_cmp_min
  import mag_cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             casc_gt_i,
  input  logic             casc_eq_i,
  input  logic             casc_lt_i,
  output logic             a_gt_b_o,
  output logic             a_eq_b_o,
  output logic             a_lt_b_o,
  output logic [WIDTH-1:0] min_o
);
  verdict_t entry_v;
  verdict_t exit_v;

  assign entry_v = '{gt: casc_gt_i, eq: casc_eq_i, lt: casc_lt_i};

  mag_cell_chain #(.WIDTH(WIDTH)) u_chain (
    .a_vec (a_i),
    .b_vec (b_i),
    .top_v (entry_v),
    .bot_v (exit_v)
  );

  assign a_gt_b_o = exit_v.gt;
  assign a_eq_b_o = exit_v.eq;
  assign a_lt_b_o = exit_v.lt;

  mag_min_pick #(.WIDTH(WIDTH)) u_pick (
    .pick_a (exit_v.lt),
    .opnd_a (a_i),
    .opnd_b (b_i),
    .picked (min_o)
  );
endmodule

// File: rtl/mag_cmp_min_chk.sv
module mag_cmp_min_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             casc_gt_i,
  input logic             casc_eq_i,
  input logic             casc_lt_i,
  input logic             a_gt_b_o,
  input logic             a_eq_b_o,
  input logic             a_lt_b_o,
  input logic [WIDTH-1:0] min_o
);
  logic solo;
  assign solo = casc_eq_i & ~casc_gt_i & ~casc_lt_i;

  always_comb begin
    if (solo) begin
      AST_GT_ORDER: assert (a_gt_b_o == (a_i > b_i)) else $error("gt flag wrong"); // R1
      AST_EQ_MATCH: assert (a_eq_b_o == (a_i == b_i)) else $error("eq flag wrong"); // R2
      AST_LT_ORDER: assert (a_lt_b_o == (a_i < b_i)) else $error("lt flag wrong"); // R3
      AST_MIN_BOUND: assert (min_o <= a_i && min_o <= b_i) else $error("min too big"); // R9
    end
    if (casc_gt_i && !casc_eq_i && !casc_lt_i) begin
      AST_GT_PASS: assert (a_gt_b_o && !a_eq_b_o && !a_lt_b_o) else $error("gt pass"); // R5
    end
    if (casc_lt_i && !casc_eq_i && !casc_gt_i) begin
      AST_LT_PASS: assert (a_lt_b_o && !a_eq_b_o && !a_gt_b_o) else $error("lt pass"); // R6
    end
    if ($onehot({casc_gt_i, casc_eq_i, casc_lt_i})) begin
      AST_FLAG_ONEHOT: assert ($onehot({a_gt_b_o, a_eq_b_o, a_lt_b_o})) else $error("flags"); // R8
    end
  end
endmodule

bind mag_cmp_min mag_cmp_min_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .casc_gt_i (casc_gt_i),
  .casc_eq_i (casc_eq_i),
  .casc_lt_i (casc_lt_i),
  .a_gt_b_o  (a_gt_b_o),
  .a_eq_b_o  (a_eq_b_o),
  .a_lt_b_o  (a_lt_b_o),
  .min_o     (min_o)
);

// File: tb/mag_cmp_min_tb.sv
module mag_cmp_min_tb;
  localparam int W = 8;
  localparam int NV = 10;
  // entry: {a[7:0], b[7:0], cascade {gt,eq,lt}, expected flags {gt,eq,lt}}
  localparam logic [21:0] VEC [NV] = '{
    {8'h0B, 8'h09, 3'b010, 3'b100},
    {8'h09, 8'h0B, 3'b010, 3'b001},
    {8'h5A, 8'h5A, 3'b010, 3'b010},
    {8'h80, 8'h7F, 3'b010, 3'b100},
    {8'h00, 8'hFF, 3'b010, 3'b001},
    {8'hFF, 8'hFF, 3'b010, 3'b010},
    {8'h00, 8'hFF, 3'b100, 3'b100},
    {8'hFF, 8'h00, 3'b001, 3'b001},
    {8'h33, 8'h33, 3'b000, 3'b000},
    {8'h33, 8'h33, 3'b100, 3'b100}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, mn;
  logic cg, ce, cl, og, oe, ol;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  mag_cmp_min #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .casc_gt_i(cg), .casc_eq_i(ce), .casc_lt_i(cl),
    .a_gt_b_o(og), .a_eq_b_o(oe), .a_lt_b_o(ol), .min_o(mn)
  );

  logic [2*W-1:0] wa, wb;
  logic hg, he, hl, lg, le, ll;
  logic [W-1:0] hm, lm;

  mag_cmp_min #(.WIDTH(W)) u_hi (
    .a_i(wa[2*W-1:W]), .b_i(wb[2*W-1:W]), .casc_gt_i(1'b0), .casc_eq_i(1'b1),
    .casc_lt_i(1'b0), .a_gt_b_o(hg), .a_eq_b_o(he), .a_lt_b_o(hl), .min_o(hm)
  );
  mag_cmp_min #(.WIDTH(W)) u_lo (
    .a_i(wa[W-1:0]), .b_i(wb[W-1:0]), .casc_gt_i(hg), .casc_eq_i(he),
    .casc_lt_i(hl), .a_gt_b_o(lg), .a_eq_b_o(le), .a_lt_b_o(ll), .min_o(lm)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb,
                       input logic [2:0] cas);
    @(posedge clk);
    a = va; b = vb; {cg, ce, cl} = cas;
    @(negedge clk);
  endtask

  task automatic chain(input logic [2*W-1:0] va, input logic [2*W-1:0] vb);
    logic [2:0] e;
    @(posedge clk);
    wa = va; wb = vb;
    @(negedge clk);
    e = {va > vb, va == vb, va < vb};
    check({lg, le, ll} == e, "R10 chain", {29'd0, lg, le, ll}, {29'd0, e});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; {cg, ce, cl} = 3'b000; wa = '0; wb = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: idle cascade all low gives all flags low
    check({og, oe, ol} == 3'b000, "R7 idle", {29'd0, og, oe, ol}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] ef;
      logic [W-1:0] em;
      apply(VEC[i][21:14], VEC[i][13:6], VEC[i][5:3]);
      ef = VEC[i][2:0];
      em = ef[0] ? VEC[i][21:14] : VEC[i][13:6];
      // R1 R2 R3 R4 R5 R6 R7 flags from table
      check({og, oe, ol} == ef, "R1-table flags R4 R5 R6", {29'd0, og, oe, ol}, {29'd0, ef});
      check(mn == em, "R9 table min", {24'd0, mn}, {24'd0, em});
    end

    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = (i % 4 == 0) ? ra ^ W'(1 << (i % W)) : W'($urandom);
      apply(ra, rb, 3'b010);
      check(og == (ra > rb), "R1 gt", {31'd0, og}, {31'd0, ra > rb});
      check(oe == (ra == rb), "R2 eq", {31'd0, oe}, {31'd0, ra == rb});
      check(ol == (ra < rb), "R3 lt", {31'd0, ol}, {31'd0, ra < rb});
      check($onehot({og, oe, ol}), "R8 onehot", {29'd0, og, oe, ol}, 32'd0);
      check(mn == ((ra < rb) ? ra : rb), "R9 min", {24'd0, mn},
            {24'd0, (ra < rb) ? ra : rb});
    end

    // R4: low bits cannot override the top differing bit
    apply(8'h80, 8'h7F, 3'b010);
    check(og && !ol, "R4 msb wins", {31'd0, og}, 32'd1);
    // R5 / R6 forced cascade over opposite operands
    apply(8'h01, 8'hFE, 3'b100);
    check({og, oe, ol} == 3'b100, "R5 gt pass", {29'd0, og, oe, ol}, 32'd4);
    check(mn == 8'hFE, "R9 min under gt", {24'd0, mn}, 32'hFE);
    apply(8'hFE, 8'h01, 3'b001);
    check({og, oe, ol} == 3'b001, "R6 lt pass", {29'd0, og, oe, ol}, 32'd1);
    check(mn == 8'hFE, "R9 min under lt", {24'd0, mn}, 32'hFE);
    // R9 tie gives B (equal values, so observe flag path too)
    apply(8'hA5, 8'hA5, 3'b010);
    check(mn == 8'hA5 && !ol, "R9 tie", {24'd0, mn}, 32'hA5);

    chain(16'h1234, 16'h1234);
    chain(16'h1235, 16'h1234);
    chain(16'h1233, 16'h1234);
    chain(16'h0100, 16'h00FF);
    chain(16'h00FF, 16'h0100);
    for (int i = 0; i < 200; i++) begin
      logic [2*W-1:0] ra, rb;
      ra = (2*W)'($urandom);
      rb = (i % 2 == 0) ? {ra[2*W-1:W], W'($urandom)} : (2*W)'($urandom);
      chain(ra, rb);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule